// File: doc/BRIEF.md
# Two-Wire Byte Sequencer

This block runs one of two serial instructions against an 8-bit accumulator. A transmit instruction sends the accumulator out one bit per clock, most significant bit first. A receive instruction collects one byte from the serial input, most significant bit first, and writes it into the accumulator. Both instructions follow the same fixed run of single-cycle slots. Slot 1 carries a start bit. Slots 2 to 9 carry the data. Slot 10 is the acknowledge slot, slot 11 the stop slot, and slot 12 is kept for the next instruction fetch.

A host presents an opcode and pulses `start`. While `busy` is high the block drives the serial clock enable, the send (drive) enable and the serial data line. It signals the end of the run with a one-cycle `fetch` pulse in slot 12. The start bit, the acknowledge and the stop bit are framing only, and none of them is checked. While the block is idle, the host can load the accumulator directly.

Top module: `two_wire_seq`

## Requirements
- R1: After reset, `busy`, `fetch`, `sclk_en` and `drive_en` are 0, `sdo` is 1 and `acc_q` is 0.
- R2: A `start` pulse begins a run only when the block is idle and `opcode` is 8'b10001001 (transmit) or 8'b10010010 (receive). With any other opcode the block stays idle.
- R3: In a transmit run, `sdo` is 0 in slot 1, then acc[7] down to acc[0] in slots 2 to 9, 1 (released) in slot 10, 0 in slot 11 and 1 in slot 12.
- R4: In a transmit run, `sclk_en` and `drive_en` are both 1 in slots 1 to 11 and both 0 in slot 12.
- R5: The value on `sdi` during the acknowledge slot of a transmit run has no effect on the outputs, the slot timing or the accumulator.
- R6: In a receive run, `sdi` is sampled at the end of slots 2 to 9, MSB first, and the sampled byte is the new accumulator value. Values on `sdi` in slots 1, 10 and 11 are ignored.
- R7: In a receive run, `sclk_en` is 1 in slots 1 to 11, and `drive_en` is 1 only in slot 10, where `sdo` is 0. In every other slot `sdo` is 1.
- R8: `acc_q` does not change while `busy` is 1. A receive run writes the accumulator at the clock edge that ends slot 12. A transmit run leaves it unchanged.
- R9: A `start` pulse while `busy` is 1 is ignored, and the run continues unchanged.
- R10: `busy` is 1 for exactly 12 cycles, starting in the cycle after the accepted `start`. `fetch` is 1 only in the 12th of them.
- R11: `acc_load` writes `acc_wdata` into the accumulator only when the block is idle and no run is being started. While busy, it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that launches the instruction on `opcode` |
| opcode | input | 8 | Instruction code |
| acc_load | input | 1 | Write `acc_wdata` into the accumulator when idle |
| acc_wdata | input | 8 | Accumulator write data |
| acc_q | output | 8 | Accumulator value |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, 1 when not driving |
| sclk_en | output | 1 | Per-slot serial clock enable |
| drive_en | output | 1 | Send enable: the block drives the data line |
| busy | output | 1 | A run is in progress (slots 1 to 12) |
| fetch | output | 1 | Fetch slot pulse (slot 12) |

## Verification
Transmit runs use bytes such as 0x00, 0xFF, 0xA5 and random values. An asymmetric byte shows that the bit order is MSB first and that no slot is off by one, and the all-zero and all-one bytes show the framing zeros apart from the data. Receive runs put random or fixed bytes on `sdi` in the data slots and random garbage in the framing slots, which shows whether only slots 2 to 9 are sampled. Some runs force the acknowledge to 1 or inject a second `start` and an `acc_load` in mid-run, which separates the ignored inputs from those that act. A bad opcode shows that decoding rejects unknown codes.

// File: rtl/two_wire_seq_pkg.sv
package two_wire_seq_pkg;
  localparam logic [7:0] OP_XMIT = 8'b10001001;
  localparam logic [7:0] OP_RECV = 8'b10010010;
  typedef enum logic {MODE_XMIT = 1'b0, MODE_RECV = 1'b1} seq_mode_t;
endpackage

// File: rtl/seq_slot_ctr.sv
module seq_slot_ctr #(
  parameter int NSLOT = 12,
  localparam int SW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  output logic [SW-1:0] slot,
  output logic          busy
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT);

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else if (slot == '0) begin
      if (launch) slot <= SW'(1);
    end else if (slot == LAST) slot <= '0;
    else slot <= slot + SW'(1);
  end

  assign busy = (slot != '0);

  assert_slot_range_R10: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST);
  assert_slot_step_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && slot != LAST) |=> (slot == $past(slot) + SW'(1)));
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) value <= '0;
    else if (load) value <= load_val;
    else if (shift_en) value <= {value[W-2:0], sdi};
  end

  assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en) |=> (value[0] == $past(sdi)));
endmodule

// File: rtl/two_wire_seq.sv
module two_wire_seq
  import two_wire_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NSLOT = DATA_W + 4,
  localparam int SW = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              acc_load,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_q,
  input  logic              sdi,
  output logic              sdo,
  output logic              sclk_en,
  output logic              drive_en,
  output logic              busy,
  output logic              fetch
);
  localparam logic [SW-1:0] S_START = SW'(1);
  localparam logic [SW-1:0] S_DLAST = SW'(DATA_W + 1);
  localparam logic [SW-1:0] S_ACK   = SW'(DATA_W + 2);
  localparam logic [SW-1:0] S_STOP  = SW'(DATA_W + 3);
  localparam logic [SW-1:0] S_FETCH = SW'(NSLOT);

  logic [SW-1:0]     slot;
  logic [DATA_W-1:0] sh;
  seq_mode_t         mode;
  logic              op_ok, launch, in_data, in_frame, is_ack;

  assign op_ok  = (opcode == OP_XMIT) || (opcode == OP_RECV);
  assign launch = start && !busy && op_ok;

  seq_slot_ctr #(.NSLOT(NSLOT)) u_ctr (
    .clk(clk), .rst(rst), .launch(launch), .slot(slot), .busy(busy)
  );

  assign in_data  = busy && (slot > S_START) && (slot <= S_DLAST);
  assign in_frame = busy && (slot <= S_STOP);
  assign is_ack   = busy && (slot == S_ACK);
  assign fetch    = busy && (slot == S_FETCH);

  seq_shifter #(.W(DATA_W)) u_sh (
    .clk(clk), .rst(rst), .load(launch), .load_val(acc_q),
    .shift_en(in_data), .sdi(sdi), .value(sh)
  );

  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_XMIT;
    else if (launch) mode <= (opcode == OP_RECV) ? MODE_RECV : MODE_XMIT;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (fetch && mode == MODE_RECV) acc_q <= sh;
    else if (acc_load && !busy && !launch) acc_q <= acc_wdata;
  end

  always_comb begin
    sclk_en  = in_frame;
    drive_en = 1'b0;
    sdo      = 1'b1;
    if (mode == MODE_XMIT) begin
      drive_en = in_frame;
      if (in_data) sdo = sh[DATA_W-1];
      else if (in_frame && !is_ack) sdo = 1'b0;
    end else if (is_ack) begin
      drive_en = 1'b1;
      sdo      = 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk_en && !drive_en && sdo));
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(acc_q));
  assert_fetch_end_R10: assert property (@(posedge clk) disable iff (rst)
    fetch |=> !busy);
  assert_recv_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && mode == MODE_RECV && drive_en) |-> (slot == S_ACK && !sdo));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !fetch) |=> (busy && $stable(mode)));
endmodule

// File: tb/two_wire_seq_bench.sv
module two_wire_seq_bench;
  import two_wire_seq_pkg::*;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, acc_load = 1'b0, sdi = 1'b0;
  logic [7:0] opcode = 8'h00, acc_wdata = 8'h00, acc_q;
  logic sdo, sclk_en, drive_en, busy, fetch;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  two_wire_seq u_two_wire_seq (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .acc_load(acc_load),
    .acc_wdata(acc_wdata), .acc_q(acc_q), .sdi(sdi), .sdo(sdo),
    .sclk_en(sclk_en), .drive_en(drive_en), .busy(busy), .fetch(fetch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_sdo(input bit rx, input int k, input logic [7:0] a);
    if (rx) return (k == 10) ? 1'b0 : 1'b1;
    if (k == 1 || k == 11) return 1'b0;
    if (k >= 2 && k <= 9) return a[9-k];
    return 1'b1;
  endfunction

  function automatic bit exp_drv(input bit rx, input int k);
    return rx ? (k == 10) : (k <= 11);
  endfunction

  task automatic load_acc(input logic [7:0] v);
    @(negedge clk); acc_load = 1'b1; acc_wdata = v;
    @(negedge clk); acc_load = 1'b0;
    chk(acc_q == v, "R11 idle load", acc_q, v);
  endtask

  task automatic run_op(input bit rx, input logic [7:0] a, input logic [7:0] rb,
                        input bit ack, input bit poke);
    load_acc(a);
    opcode = rx ? OP_RECV : OP_XMIT; start = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      start = poke && (k == 3);
      if (poke && k == 3) opcode = rx ? OP_XMIT : OP_RECV;
      acc_load = poke && (k == 5); acc_wdata = ~a;
      chk(busy == 1'b1, (poke && k > 3) ? "R9 busy" : "R10 busy", busy, 1);
      chk(fetch == (k == 12), "R10 fetch", fetch, k == 12);
      chk(sclk_en == (k <= 11), rx ? "R7 sclk" : "R4 sclk", sclk_en, k <= 11);
      chk(drive_en == exp_drv(rx, k), rx ? "R7 drive" : "R4 drive", drive_en, exp_drv(rx, k));
      chk(sdo == exp_sdo(rx, k, a), rx ? "R7 sdo" : (k > 10 ? "R5 sdo" : "R3 sdo"),
          sdo, exp_sdo(rx, k, a));
      chk(acc_q == a, "R8 hold", acc_q, a);
      if (k >= 2 && k <= 9) sdi = rb[9-k];
      else if (k == 10) sdi = ack;
      else sdi = 1'($urandom);
    end
    @(negedge clk);
    start = 1'b0; acc_load = 1'b0;
    chk(busy == 1'b0 && fetch == 1'b0, "R10 end", busy, 0);
    chk(acc_q == (rx ? rb : a), rx ? "R6 result" : "R5 acc", acc_q, rx ? rb : a);
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !fetch && !sclk_en && !drive_en && sdo && acc_q == 8'h00,
        "R1 reset", {busy, fetch, sclk_en, drive_en, sdo}, 5'b00001);
    // R2 bad opcode
    opcode = 8'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0 && sclk_en == 1'b0, "R2 bad opcode", busy, 0);
    opcode = 8'b10001010; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0, "R2 near opcode", busy, 0);
    // directed corners
    run_op(1'b0, 8'hA5, 8'h00, 1'b1, 1'b0);   // R3 R5 ack high
    run_op(1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    run_op(1'b0, 8'hFF, 8'h00, 1'b1, 1'b1);   // R9 R11 poke
    run_op(1'b1, 8'h3C, 8'h81, 1'b1, 1'b0);   // R6
    run_op(1'b1, 8'hFF, 8'h00, 1'b0, 1'b1);   // R9 R11 poke on receive
    run_op(1'b1, 8'h00, 8'hFF, 1'b1, 1'b0);
    // random
    for (int i = 0; i < 40; i++)
      run_op(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule